// File: doc/BRIEF.md
# Byte Program Pulse-and-Verify Sequencer

This block sits on the host side of a multiple-time-programmable memory and carries out the byte programming loop on its behalf. A job begins with a one-cycle start request and a byte count. The block then pulls address and data pairs from a valid/ready stream. Each pair may carry any address, in any order. For every byte it issues command writes and verify reads on a simple device port, and it holds the programming-voltage enable high for the whole job.

A programming attempt is one pulse. A pulse is a set-up command, a write of the target address and data, and a wait of a set length. A verify command follows, then a second wait, then a read of the byte, which is compared with the intended value. A byte that does not match gets another pulse, up to a parameter limit. A byte that matches releases the stream for the next pair. When every byte has verified, the block writes the read-mode command, drops the voltage enable and pulses done. If a byte uses up its pulse budget, the job stops at once. The block then drops the voltage enable and raises an error flag together with the failing address. Both wait lengths and the pulse budget are parameters, counted in clock cycles and in pulses.

Top module: `mtp_prog_seq`

## Requirements
- R1: After reset, hv_en_o, in_ready_o, dev_wr_o, dev_rd_o, done_o and err_o are all low.
- R2: A start request raises hv_en_o on the next cycle. hv_en_o stays high until the job ends and is low when done_o pulses.
- R3: Each pulse is three steps. First, a write of the set-up command 40h. Next, on the following cycle, a write of the pair's data at the pair's address. Then, exactly PGM_CYC idle cycles later, a write of the verify command C0h. Exactly VFY_CYC idle cycles after that comes one read strobe at the pair's address.
- R4: in_ready_o is high only while the block waits for a pair. While in_valid_i is low, the block stalls and makes no device write.
- R5: A byte whose read value differs from its data gets another pulse. If it still fails after MAX_PULSES pulses, the job ends: err_o goes high, fail_addr_o holds that byte's address, and no further pair is accepted.
- R6: The pulse budget restarts for each new byte, so every byte may use up to MAX_PULSES pulses.
- R7: With SKIP_BLANK set, a pair whose data is all ones (FFh) is accepted without any device write or read.
- R8: After the last byte verifies, the block writes the read-mode command 00h once, then pulses done_o for one cycle with err_o low.
- R9: Pairs are programmed at the addresses they carry, in the order given, whatever that order is.
- R10: A start with a count of zero writes only the 00h command and then pulses done_o.
- R11: A job that ends in error writes no 00h command.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a job (ignored while a job runs) |
| count_i | input | CNT_W | Number of pairs in the job |
| in_valid_i | input | 1 | Pair on in_addr_i/in_data_i is valid |
| in_ready_o | output | 1 | Block takes the pair this cycle |
| in_addr_i | input | AW | Target byte address |
| in_data_i | input | DW | Target byte value |
| dev_wr_o | output | 1 | Device write strobe |
| dev_rd_o | output | 1 | Device read strobe; dev_rdata_i sampled in the same cycle |
| dev_addr_o | output | AW | Device address |
| dev_wdata_o | output | DW | Device write data or command |
| dev_rdata_i | input | DW | Device read data |
| hv_en_o | output | 1 | Programming-voltage enable |
| done_o | output | 1 | One-cycle job completion pulse |
| err_o | output | 1 | Job ended on an exhausted pulse budget (held until next start) |
| fail_addr_o | output | AW | Address of the byte that failed |

## Verification
Two events can land on one verify read: the end of the pulse budget, and the last byte of a job. Whichever wins decides whether the job ends with the 00h command or with the error flag. The bench sets its device model so that the final byte needs exactly MAX_PULSES pulses in one job and one more in another. It then checks the done pulse, err_o, fail_addr_o, the count of 00h commands and the number of pulses used against values it works out from the needed pulse counts. A single-byte sweep over every needed count from zero to past the budget covers the same boundary on the first byte.

// File: rtl/mtp_prog_pkg.sv
package mtp_prog_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FETCH,
      ST_SETUP,
      ST_PROG,
      ST_PWAIT,
      ST_VCMD,
      ST_VWAIT,
      ST_VREAD,
      ST_NEXT,
      ST_FINISH
   } seq_state_t;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mtp_wait_timer.sv
module mtp_wait_timer #(
   parameter int unsigned TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] load_val_i,
   output logic          expired_o
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/mtp_pulse_budget.sv
module mtp_pulse_budget #(
   parameter int unsigned MAX_PULSES = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);

   localparam int unsigned PW = $clog2(MAX_PULSES + 1);
   localparam logic [PW-1:0] LAST_VAL = PW'(MAX_PULSES - 1);

   logic [PW-1:0] used_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used_q <= '0;
      end else if (clr_i) begin
         used_q <= '0;
      end else if (inc_i && (used_q != LAST_VAL)) begin
         used_q <= used_q + 1'b1;
      end
   end

   assign last_o = (used_q == LAST_VAL);

endmodule

// File: rtl/mtp_byte_slot.sv
module mtp_byte_slot #(
   parameter int unsigned AW         = 17,
   parameter int unsigned DW         = 8,
   parameter bit          SKIP_BLANK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] data_i,
   input  logic [DW-1:0] rdata_i,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] data_o,
   output logic          blank_o,
   output logic          match_o
);

   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (load_i) begin
         addr_q <= addr_i;
         data_q <= data_i;
      end
   end

   generate
      if (SKIP_BLANK) begin : g_skip
         assign blank_o = &data_i;
      end else begin : g_noskip
         assign blank_o = 1'b0;
      end
   endgenerate

   assign addr_o  = addr_q;
   assign data_o  = data_q;
   assign match_o = (rdata_i == data_q);

endmodule

// File: rtl/mtp_byte_tally.sv
module mtp_byte_tally #(
   parameter int unsigned CNT_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             dec_i,
   output logic             last_o
);

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (load_i) begin
         left_q <= count_i;
      end else if (dec_i && (left_q != '0)) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign last_o = (left_q == CNT_W'(1));

endmodule

// File: rtl/mtp_prog_seq.sv
module mtp_prog_seq
   import mtp_prog_pkg::*;
#(
   parameter int unsigned   AW          = 17,
   parameter int unsigned   DW          = 8,
   parameter int unsigned   CNT_W       = 18,
   parameter int unsigned   MAX_PULSES  = 25,
   parameter int unsigned   PGM_CYC     = 500,
   parameter int unsigned   VFY_CYC     = 300,
   parameter bit            SKIP_BLANK  = 1'b1,
   parameter logic [DW-1:0] CMD_SETUP   = DW'('h40),
   parameter logic [DW-1:0] CMD_VERIFY  = DW'('hC0),
   parameter logic [DW-1:0] CMD_READ    = DW'('h00)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             in_valid_i,
   output logic             in_ready_o,
   input  logic [AW-1:0]    in_addr_i,
   input  logic [DW-1:0]    in_data_i,
   output logic             dev_wr_o,
   output logic             dev_rd_o,
   output logic [AW-1:0]    dev_addr_o,
   output logic [DW-1:0]    dev_wdata_o,
   input  logic [DW-1:0]    dev_rdata_i,
   output logic             hv_en_o,
   output logic             done_o,
   output logic             err_o,
   output logic [AW-1:0]    fail_addr_o
);

   localparam int unsigned TMAX = max_of(PGM_CYC, VFY_CYC);
   localparam int unsigned TW   = $clog2(TMAX + 1);
   localparam logic [TW-1:0] PGM_LOAD = TW'(PGM_CYC - 1);
   localparam logic [TW-1:0] VFY_LOAD = TW'(VFY_CYC - 1);

   generate
      if (MAX_PULSES < 1) begin : g_bad_pulses
         $error("MAX_PULSES must be at least 1");
      end
      if ((PGM_CYC < 1) || (VFY_CYC < 1)) begin : g_bad_wait
         $error("PGM_CYC and VFY_CYC must be at least 1");
      end
      if ((AW < 1) || (DW < 1) || (CNT_W < 1)) begin : g_bad_width
         $error("AW, DW and CNT_W must be at least 1");
      end
   endgenerate

   seq_state_t state_q, state_d;

   logic          tmr_load, tmr_expired;
   logic [TW-1:0] tmr_val;
   logic          bud_clr, bud_inc, bud_last;
   logic          slot_load, slot_blank, slot_match;
   logic [AW-1:0] slot_addr;
   logic [DW-1:0] slot_data;
   logic          tal_load, tal_dec, tal_last;
   logic          accept, fail_now, finish_now;
   logic          done_q, err_q;
   logic [AW-1:0] fail_addr_q;

   assign accept     = (state_q == ST_FETCH) && in_valid_i;
   assign fail_now   = (state_q == ST_VREAD) && !slot_match && bud_last;
   assign finish_now = (state_q == ST_FINISH);

   mtp_wait_timer #(.TW(TW)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .expired_o  (tmr_expired)
   );

   mtp_pulse_budget #(.MAX_PULSES(MAX_PULSES)) u_bud (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (bud_clr),
      .inc_i  (bud_inc),
      .last_o (bud_last)
   );

   mtp_byte_slot #(.AW(AW), .DW(DW), .SKIP_BLANK(SKIP_BLANK)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (slot_load),
      .addr_i  (in_addr_i),
      .data_i  (in_data_i),
      .rdata_i (dev_rdata_i),
      .addr_o  (slot_addr),
      .data_o  (slot_data),
      .blank_o (slot_blank),
      .match_o (slot_match)
   );

   mtp_byte_tally #(.CNT_W(CNT_W)) u_tal (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (tal_load),
      .count_i (count_i),
      .dec_i   (tal_dec),
      .last_o  (tal_last)
   );

   always_comb begin
      state_d   = state_q;
      tmr_load  = 1'b0;
      tmr_val   = PGM_LOAD;
      bud_clr   = 1'b0;
      bud_inc   = 1'b0;
      slot_load = 1'b0;
      tal_load  = 1'b0;
      tal_dec   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               tal_load = 1'b1;
               state_d  = (count_i == '0) ? ST_FINISH : ST_FETCH;
            end
         end
         ST_FETCH: begin
            if (in_valid_i) begin
               slot_load = 1'b1;
               bud_clr   = 1'b1;
               state_d   = slot_blank ? ST_NEXT : ST_SETUP;
            end
         end
         ST_SETUP: state_d = ST_PROG;
         ST_PROG: begin
            tmr_load = 1'b1;
            tmr_val  = PGM_LOAD;
            state_d  = ST_PWAIT;
         end
         ST_PWAIT: if (tmr_expired) state_d = ST_VCMD;
         ST_VCMD: begin
            tmr_load = 1'b1;
            tmr_val  = VFY_LOAD;
            state_d  = ST_VWAIT;
         end
         ST_VWAIT: if (tmr_expired) state_d = ST_VREAD;
         ST_VREAD: begin
            if (slot_match) begin
               state_d = ST_NEXT;
            end else if (bud_last) begin
               state_d = ST_IDLE;
            end else begin
               bud_inc = 1'b1;
               state_d = ST_SETUP;
            end
         end
         ST_NEXT: begin
            tal_dec = 1'b1;
            state_d = tal_last ? ST_FINISH : ST_FETCH;
         end
         ST_FINISH: state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q      <= 1'b0;
         err_q       <= 1'b0;
         fail_addr_q <= '0;
      end else begin
         done_q <= fail_now || finish_now;
         if ((state_q == ST_IDLE) && start_i) begin
            err_q       <= 1'b0;
            fail_addr_q <= '0;
         end else if (fail_now) begin
            err_q       <= 1'b1;
            fail_addr_q <= slot_addr;
         end
      end
   end

   always_comb begin
      dev_wr_o    = 1'b0;
      dev_rd_o    = 1'b0;
      dev_wdata_o = CMD_READ;
      unique case (state_q)
         ST_SETUP:  begin dev_wr_o = 1'b1; dev_wdata_o = CMD_SETUP;  end
         ST_PROG:   begin dev_wr_o = 1'b1; dev_wdata_o = slot_data;  end
         ST_VCMD:   begin dev_wr_o = 1'b1; dev_wdata_o = CMD_VERIFY; end
         ST_VREAD:  dev_rd_o = 1'b1;
         ST_FINISH: begin dev_wr_o = 1'b1; dev_wdata_o = CMD_READ;   end
         default:   ;
      endcase
   end

   assign dev_addr_o  = slot_addr;
   assign in_ready_o  = (state_q == ST_FETCH);
   assign hv_en_o     = (state_q != ST_IDLE);
   assign done_o      = done_q;
   assign err_o       = err_q;
   assign fail_addr_o = fail_addr_q;

   logic unused_accept;
   assign unused_accept = accept;

endmodule

// File: rtl/mtp_prog_seq_chk.sv
module mtp_prog_seq_chk #(
   parameter int unsigned   AW         = 17,
   parameter int unsigned   DW         = 8,
   parameter int unsigned   MAX_PULSES = 25,
   parameter int unsigned   PGM_CYC    = 500,
   parameter int unsigned   VFY_CYC    = 300,
   parameter logic [DW-1:0] CMD_SETUP  = DW'('h40),
   parameter logic [DW-1:0] CMD_VERIFY = DW'('hC0)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid_i,
   input logic          in_ready_o,
   input logic          dev_wr_o,
   input logic          dev_rd_o,
   input logic [AW-1:0] dev_addr_o,
   input logic [DW-1:0] dev_wdata_o,
   input logic          hv_en_o,
   input logic          done_o,
   input logic          err_o
);

   logic        after_setup_q;
   logic        wait_vcmd_q;
   logic        wait_read_q;
   logic [31:0] gap_q;
   logic [31:0] pulses_q;
   logic        data_wr;

   assign data_wr = dev_wr_o && after_setup_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         after_setup_q <= 1'b0;
         wait_vcmd_q   <= 1'b0;
         wait_read_q   <= 1'b0;
         gap_q         <= '0;
         pulses_q      <= '0;
      end else begin
         if (dev_wr_o) after_setup_q <= !after_setup_q && (dev_wdata_o == CMD_SETUP);
         if (data_wr) begin
            wait_vcmd_q <= 1'b1;
            gap_q       <= 32'd1;
         end else if (dev_wr_o && wait_vcmd_q) begin
            wait_vcmd_q <= 1'b0;
            wait_read_q <= 1'b1;
            gap_q       <= 32'd1;
         end else if (dev_rd_o) begin
            wait_read_q <= 1'b0;
         end else begin
            gap_q <= gap_q + 1'b1;
         end
         if (in_valid_i && in_ready_o) pulses_q <= '0;
         else if (data_wr)             pulses_q <= pulses_q + 1'b1;
      end
   end

   AST_SETUP_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_wr_o && (dev_wdata_o == CMD_SETUP) && !after_setup_q) |=> dev_wr_o); // R3

   AST_PGM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_wr_o && wait_vcmd_q) |-> (gap_q == PGM_CYC + 1) && (dev_wdata_o == CMD_VERIFY)); // R3

   AST_VFY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rd_o |-> wait_read_q && (gap_q == VFY_CYC + 1)); // R3

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_wr_o && dev_rd_o)); // R3

   AST_READY_HV: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready_o |-> hv_en_o && !dev_wr_o && !dev_rd_o); // R4

   AST_PULSE_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
      pulses_q <= MAX_PULSES); // R5

   AST_DONE_HV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !hv_en_o); // R2

   AST_ERR_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !in_ready_o); // R5

   logic [AW-1:0] unused_addr;
   assign unused_addr = dev_addr_o;

endmodule

bind mtp_prog_seq mtp_prog_seq_chk #(
   .AW(AW), .DW(DW), .MAX_PULSES(MAX_PULSES), .PGM_CYC(PGM_CYC),
   .VFY_CYC(VFY_CYC), .CMD_SETUP(CMD_SETUP), .CMD_VERIFY(CMD_VERIFY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
   .dev_wr_o(dev_wr_o), .dev_rd_o(dev_rd_o), .dev_addr_o(dev_addr_o),
   .dev_wdata_o(dev_wdata_o), .hv_en_o(hv_en_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/sim_mtp_prog_seq.sv
module sim_mtp_prog_seq;

   localparam int CLK_PERIOD = 10;
   localparam int AW   = 4;
   localparam int DW   = 8;
   localparam int CW   = 5;
   localparam int MAXP = 4;
   localparam int PCY  = 3;
   localparam int VCY  = 2;
   localparam int ND   = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] count = '0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [AW-1:0] in_addr = '0;
   logic [DW-1:0] in_data = '0;
   logic          dev_wr, dev_rd, hv_en, done, err;
   logic [AW-1:0] dev_addr, fail_addr;
   logic [DW-1:0] dev_wdata, dev_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   mtp_prog_seq #(
      .AW(AW), .DW(DW), .CNT_W(CW), .MAX_PULSES(MAXP),
      .PGM_CYC(PCY), .VFY_CYC(VCY), .SKIP_BLANK(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .count_i(count),
      .in_valid_i(in_valid), .in_ready_o(in_ready), .in_addr_i(in_addr),
      .in_data_i(in_data), .dev_wr_o(dev_wr), .dev_rd_o(dev_rd),
      .dev_addr_o(dev_addr), .dev_wdata_o(dev_wdata), .dev_rdata_i(dev_rdata),
      .hv_en_o(hv_en), .done_o(done), .err_o(err), .fail_addr_o(fail_addr)
   );

   // device model: a cell takes its data on the need-th pulse
   logic [7:0] mem [ND];
   int         need [ND];
   logic       armed = 1'b0, expv = 1'b0, expr = 1'b0, done_seen = 1'b0;
   int         cyc = 0, t0 = 0, t1 = 0;
   int         pulses = 0, cmd00 = 0, wr_cnt = 0, viol = 0, accepted = 0;

   assign dev_rdata = mem[dev_addr];

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (dev_wr) begin
         wr_cnt = wr_cnt + 1;
         if (armed) begin
            pulses = pulses + 1;
            if (need[dev_addr] > 1) need[dev_addr] = need[dev_addr] - 1;
            else begin
               mem[dev_addr] = mem[dev_addr] & dev_wdata;
               need[dev_addr] = 0;
            end
            armed = 1'b0;
            expv  = 1'b1;
            t0    = cyc;
         end else begin
            if (expv) begin
               if (dev_wdata != 8'hC0 || cyc - t0 != PCY + 1) viol = viol + 1;
               expv = 1'b0;
               expr = 1'b1;
               t1   = cyc;
            end else if (dev_wdata == 8'h00) cmd00 = cmd00 + 1;
            armed = (dev_wdata == 8'h40);
         end
      end
      if (dev_rd) begin
         if (!expr || cyc - t1 != VCY + 1) viol = viol + 1;
         expr = 1'b0;
      end
      if (in_valid && in_ready) accepted = accepted + 1;
      if (done) done_seen = 1'b1;
   end

   int total = 0, bad = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   logic [AW-1:0] ja [ND];
   logic [DW-1:0] jd [ND];
   logic [7:0]    emem [ND];
   int            eneed [ND];

   task automatic init_dev(input logic [7:0] fill);
      for (int i = 0; i < ND; i++) begin
         mem[i] = fill; need[i] = 1; emem[i] = fill; eneed[i] = 1;
      end
   endtask

   task automatic set_need(input int a, input int k);
      need[a] = k; eneed[a] = k;
   endtask

   task automatic run_job(input int n, input int stall, input string tag);
      int  e_pulses = 0, e_acc = 0, e_fail_a = 0, wr0;
      bit  e_err = 1'b0;
      // expected outcome, worked out byte by byte
      for (int i = 0; i < n && !e_err; i++) begin
         int  a = int'(ja[i]);
         bit  ok = 1'b0;
         e_acc++;
         if (jd[i] == 8'hFF) continue;
         for (int p = 0; p < MAXP && !ok; p++) begin
            e_pulses++;
            if (eneed[a] > 1) eneed[a]--;
            else begin emem[a] = emem[a] & jd[i]; eneed[a] = 0; end
            ok = (emem[a] == jd[i]);
         end
         if (!ok) begin e_err = 1'b1; e_fail_a = a; end
      end
      pulses = 0; cmd00 = 0; viol = 0; accepted = 0; done_seen = 1'b0;
      @(negedge clk);
      start = 1'b1; count = CW'(n);
      @(negedge clk);
      start = 1'b0;
      chk(hv_en == 1'b1, {tag, " R2 hv on after start"}, int'(hv_en), 1);
      if (stall > 0) begin
         wr0 = wr_cnt;
         for (int s = 0; s < stall; s++) begin
            chk(in_ready == 1'b1, {tag, " R4 ready while stalled"}, int'(in_ready), 1);
            @(negedge clk);
         end
         chk(wr_cnt == wr0, {tag, " R4 no write while stalled"}, wr_cnt - wr0, 0);
      end
      for (int i = 0; i < n; i++) begin
         if (done_seen) break;
         in_valid = 1'b1; in_addr = ja[i]; in_data = jd[i];
         forever begin
            if (in_ready) begin @(posedge clk); break; end
            if (done_seen) break;
            @(negedge clk);
         end
         @(negedge clk);
         in_valid = 1'b0;
      end
      in_valid = 1'b0;
      while (!done_seen) @(negedge clk);
      @(negedge clk);
      chk(hv_en == 1'b0, {tag, " R2 hv off at end"}, int'(hv_en), 0);
      chk(err == e_err, {tag, " R5 R8 error flag"}, int'(err), int'(e_err));
      if (e_err)
         chk(int'(fail_addr) == e_fail_a, {tag, " R5 fail address"}, int'(fail_addr), e_fail_a);
      chk(pulses == e_pulses, {tag, " R6 R7 pulse total"}, pulses, e_pulses);
      chk(accepted == e_acc, {tag, " R5 pairs taken"}, accepted, e_acc);
      chk(cmd00 == (e_err ? 0 : 1), {tag, " R8 R10 R11 read-mode cmd"}, cmd00, e_err ? 0 : 1);
      chk(viol == 0, {tag, " R3 pulse sequence timing"}, viol, 0);
      begin
         int mism = 0;
         for (int i = 0; i < ND; i++) if (mem[i] != emem[i]) mism++;
         chk(mism == 0, {tag, " R9 array contents"}, mism, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      init_dev(8'hFF);
      repeat (3) @(negedge clk);
      chk(!hv_en && !in_ready && !dev_wr && !dev_rd && !done && !err,
          "R1 reset outputs", int'({hv_en, in_ready, dev_wr, dev_rd, done, err}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: empty job
      run_job(0, 0, "empty");

      // R3 R8: sequential bytes, one pulse each, with a stall first (R4)
      init_dev(8'hFF);
      for (int i = 0; i < 4; i++) begin ja[i] = AW'(i); jd[i] = 8'h10 + 8'(i); end
      run_job(4, 5, "seq");

      // R6 R9: scattered order, needs up to exactly the budget on the last byte
      init_dev(8'hFF);
      ja[0] = 4'd9; ja[1] = 4'd2; ja[2] = 4'd14; ja[3] = 4'd5;
      jd[0] = 8'h3C; jd[1] = 8'h81; jd[2] = 8'h00; jd[3] = 8'h7E;
      set_need(9, 2); set_need(2, 3); set_need(14, 1); set_need(5, MAXP);
      run_job(4, 0, "scatter");

      // R5 R11: last byte needs one pulse beyond the budget
      init_dev(8'hFF);
      ja[0] = 4'd1; ja[1] = 4'd6; jd[0] = 8'h55; jd[1] = 8'hAA;
      set_need(6, MAXP + 1);
      run_job(2, 0, "over");

      // R5: middle byte fails, later pair must not be taken
      init_dev(8'hFF);
      ja[0] = 4'd3; ja[1] = 4'd4; ja[2] = 4'd8; jd[0] = 8'h01; jd[1] = 8'h02; jd[2] = 8'h04;
      set_need(4, MAXP + 2);
      run_job(3, 0, "midfail");

      // R7: blank bytes skipped among real ones
      init_dev(8'hFF);
      ja[0] = 4'd0; ja[1] = 4'd7; ja[2] = 4'd11; jd[0] = 8'hFF; jd[1] = 8'h5A; jd[2] = 8'hFF;
      run_job(3, 0, "blank");

      // R5: a cell holding 0 where 1 is wanted can never verify
      init_dev(8'h0F);
      ja[0] = 4'd12; jd[0] = 8'hF0;
      run_job(1, 0, "stuck");

      // R9: same address twice, second value clears more bits
      init_dev(8'hFF);
      ja[0] = 4'd10; ja[1] = 4'd10; jd[0] = 8'hF3; jd[1] = 8'h33;
      run_job(2, 0, "repeat");

      // R5 R6: sweep needed pulses 0..MAXP+2 on a single byte
      for (int k = 0; k <= MAXP + 2; k++) begin
         init_dev(8'hFF);
         ja[0] = AW'(k); jd[0] = 8'hA5 ^ 8'(k);
         set_need(k, k);
         run_job(1, 0, $sformatf("sweep%0d", k));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule